// File: doc/BRIEF.md
# Bit-Serial Fuzzy Maximum / Minimum Unit

This block takes two fuzzy membership grades, A and B, that arrive one bit per clock with the most significant bit first, and streams back one bit per clock of either their maximum or their minimum. The choice between the two is fixed by a parameter. No word is ever stored. A three-state decision machine records whether the two operands have matched so far, whether A has proved larger, or whether B has. Each output bit is chosen from the incoming bit pair, according to that decision.

A new operation begins with a one-cycle `start` pulse. Data bits are marked by `bit_vld`, and gaps between them are allowed. Once `WIDTH` data bits have been accepted, `done` is raised and further bits are ignored until the next `start`. If `start` and a data bit occur in the same cycle, that bit becomes the first bit of the new operation. Used that way, a word needs only `WIDTH` cycles. With a separate start cycle it takes `WIDTH + 1` cycles.

Top module: `fuzzy_serial_maxmin`

## Requirements
- R1: Every accepted data bit (`bit_vld` high while the block is accepting) produces `out_vld` high and one result bit in the same cycle. Bits arrive most significant first, so over a full operation the stream of results forms the selected word, most significant bit first.
- R2: A synchronous active-low `rst_n`, or a `start` pulse (active high), returns the decision to "equal so far", clears the bit count and drops `done` on the next cycle.
- R3: While the decision is "equal so far" and the A and B bits agree, the output bit equals the B bit.
- R4: At the first bit position where A and B differ, the decision becomes "A larger" if the A bit is 1 and the B bit is 0, or "B larger" in the opposite case. The output bit at that position already reflects the new decision: it is 1 for the maximum and 0 for the minimum. The decision does not change again until the next start or reset.
- R5: With `MODE_MAX` = 1, the output follows A when A is larger and follows B when B is larger. With `MODE_MAX` = 0, the selection is reversed.
- R6: `done` goes high in the cycle after the `WIDTH`-th accepted bit. It stays high until a start or reset.
- R7: While `done` is high and `start` is low, data bits are ignored: `out_vld` stays low, `done` stays high and the decision does not change.
- R8: When `start` and `bit_vld` are high in the same cycle, the start takes effect first, and that bit is processed as the first bit of a fresh operation.
- R9: A cycle with `bit_vld` low produces no output (`out_vld` low) and leaves both the decision and the bit count unchanged.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new operation, active high, one cycle |
| bit_vld | input | 1 | Marks a data bit pair on `a_bit` / `b_bit` |
| a_bit | input | 1 | Serial bit of operand A, most significant first |
| b_bit | input | 1 | Serial bit of operand B, most significant first |
| out_bit | output | 1 | Serial bit of the maximum or minimum |
| out_vld | output | 1 | `out_bit` holds a result bit this cycle |
| done | output | 1 | All `WIDTH` bits of the current operation are accepted |

## Verification
A maximum instance and a minimum instance are driven side by side, each with the same operand pairs, and the results are compared against word-level max and min computed in the bench. The operand pairs are chosen to separate the cases:
- identical words, which keep the machine in the equal state throughout;
- a difference at the most significant bit, which decides on the first bit;
- a difference only at the least significant bit, which decides on the last bit;
- a difference in the middle, which exercises the sticky selection after the decision;
- all zeros against all ones, where the minimum and maximum streams are complete opposites.

Further runs cover a gap in `bit_vld` partway through a word, bits sent after `done`, and a `start` that coincides with the first data bit. The last of these confirms that the previous operation's decision does not leak into the new one.

// File: rtl/fzs_pkg.sv
// Package fzs_pkg
// Shared types for the bit-serial fuzzy max/min unit.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package fzs_pkg;

    // Decision reached on the bits seen so far in one operation
    typedef enum logic [1:0] {
        ST_EQ  = 2'd0,   // all bits seen so far agree
        ST_AGT = 2'd1,   // A has proved larger
        ST_BGT = 2'd2    // B has proved larger
    } cmp_state_t;

endpackage

// File: rtl/fzs_bit_counter.sv
// Module fzs_bit_counter
// Counts accepted data bits of the current operation and reports when
// WIDTH bits have been taken. Decides whether the current bit is accepted.
// Assumes: start has priority over the full condition, so a bit arriving
// with start is always accepted as bit one of a new operation.
module fzs_bit_counter #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bit_vld,
    output logic take,
    output logic full
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST  = CW'(WIDTH);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Full once WIDTH bits were taken
    assign full = (cnt_q == LAST);

    // Accept when a bit is present and either a restart or room remains
    assign take = bit_vld && (start || !full);

    // Next count: restart from zero or one, otherwise step on each taken bit
    always_comb begin
        if (start) begin
            cnt_d = bit_vld ? ONE : '0;
        end else if (take) begin
            cnt_d = cnt_q + ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    // Count register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fzs_decider.sv
// Module fzs_decider
// Three-state decision machine: equal so far, A larger, B larger.
// Provides the effective state for the current cycle (start forces the
// equal state at once) and the registered state.
// Assumes: take is only high for accepted bits.
module fzs_decider
    import fzs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       take,
    input  logic       a_bit,
    input  logic       b_bit,
    output cmp_state_t eff_state,
    output cmp_state_t state_q
);
    cmp_state_t state_d;

    // A start in this cycle discards the previous decision immediately
    assign eff_state = start ? ST_EQ : state_q;

    // Leave the equal state only on the first differing accepted bit
    always_comb begin
        state_d = eff_state;
        if (take && (eff_state == ST_EQ) && (a_bit != b_bit)) begin
            state_d = a_bit ? ST_AGT : ST_BGT;
        end
    end

    // Decision register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EQ;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/fzs_out_select.sv
// Module fzs_out_select
// Picks the output bit from the current bit pair and the effective
// decision. In the equal state a differing pair is itself the decision,
// so max yields a|b and min yields a&b there.
// Assumes: MODE_MAX is 1 for maximum, 0 for minimum.
module fzs_out_select
    import fzs_pkg::*;
#(
    parameter bit MODE_MAX = 1'b1
) (
    input  cmp_state_t eff_state,
    input  logic       a_bit,
    input  logic       b_bit,
    output logic       out_bit
);
    generate
        if (MODE_MAX) begin : g_max
            // Larger operand wins
            always_comb begin
                unique case (eff_state)
                    ST_AGT:  out_bit = a_bit;
                    ST_BGT:  out_bit = b_bit;
                    default: out_bit = a_bit | b_bit;
                endcase
            end
        end else begin : g_min
            // Smaller operand wins
            always_comb begin
                unique case (eff_state)
                    ST_AGT:  out_bit = b_bit;
                    ST_BGT:  out_bit = a_bit;
                    default: out_bit = a_bit & b_bit;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/fuzzy_serial_maxmin.sv
// Module fuzzy_serial_maxmin
// Bit-serial fuzzy maximum or minimum of two WIDTH-bit grades, most
// significant bit first, one result bit per accepted input bit with no
// latency. Assumes the caller pulses start before (or with) the first bit.
module fuzzy_serial_maxmin
    import fzs_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit MODE_MAX = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bit_vld,
    input  logic a_bit,
    input  logic b_bit,
    output logic out_bit,
    output logic out_vld,
    output logic done
);
    logic       take;
    logic       full;
    cmp_state_t eff_state;
    cmp_state_t state_q;

    // Bit acceptance and completion tracking
    fzs_bit_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .bit_vld (bit_vld),
        .take    (take),
        .full    (full)
    );

    // Equal / A-larger / B-larger decision
    fzs_decider u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .take      (take),
        .a_bit     (a_bit),
        .b_bit     (b_bit),
        .eff_state (eff_state),
        .state_q   (state_q)
    );

    // Result bit selection
    fzs_out_select #(.MODE_MAX(MODE_MAX)) u_sel (
        .eff_state (eff_state),
        .a_bit     (a_bit),
        .b_bit     (b_bit),
        .out_bit   (out_bit)
    );

    assign out_vld = take;
    assign done    = full;

endmodule

// File: rtl/fzs_checker.sv
// Module fzs_checker
// Property checks for fuzzy_serial_maxmin, attached by bind below.
// Assumes it observes the top's ports and its registered decision.
module fzs_checker
    import fzs_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit MODE_MAX = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       bit_vld,
    input logic       a_bit,
    input logic       b_bit,
    input logic       out_bit,
    input logic       out_vld,
    input logic       done,
    input cmp_state_t state_q
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !bit_vld) |=> (state_q == ST_EQ && !done)); // R2

    AST_EQ_FOLLOWS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EQ && !start && out_vld && a_bit == b_bit) |-> (out_bit == b_bit)); // R3

    AST_FIRST_DIFF_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EQ && !start && out_vld && a_bit && !b_bit) |=> (state_q == ST_AGT)); // R4

    AST_DECISION_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EQ && !start) |=> (state_q == $past(state_q))); // R4

    AST_SEL_A_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AGT && !start && out_vld) |-> (out_bit == (MODE_MAX ? a_bit : b_bit))); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6

    AST_IGNORE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |-> !out_vld); // R7

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld) |-> !out_vld); // R9

endmodule

bind fuzzy_serial_maxmin fzs_checker #(.WIDTH(WIDTH), .MODE_MAX(MODE_MAX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bit_vld (bit_vld),
    .a_bit   (a_bit),
    .b_bit   (b_bit),
    .out_bit (out_bit),
    .out_vld (out_vld),
    .done    (done),
    .state_q (state_q)
);

// File: tb/fuzzy_serial_maxmin_bench.sv
// Scoreboard bench: the driver pushes one expected item per cycle, the
// monitor pops it at the falling edge and compares both instances.
module fuzzy_serial_maxmin_bench;
    localparam int W = 8;

    typedef struct {
        logic  vld;
        logic  mx;
        logic  mn;
        logic  dn;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bit_vld = 1'b0;
    logic a_bit = 1'b0;
    logic b_bit = 1'b0;
    logic mx_bit, mx_vld, mx_done;
    logic mn_bit, mn_vld, mn_done;

    int n_cmp = 0;
    int n_bad = 0;
    int bcnt  = 0;
    int cyc   = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    fuzzy_serial_maxmin #(.WIDTH(W), .MODE_MAX(1'b1)) u_fuzzy_serial_maxmin (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld),
        .a_bit(a_bit), .b_bit(b_bit),
        .out_bit(mx_bit), .out_vld(mx_vld), .done(mx_done));

    fuzzy_serial_maxmin #(.WIDTH(W), .MODE_MAX(1'b0)) u_fuzzy_serial_maxmin_min (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld),
        .a_bit(a_bit), .b_bit(b_bit),
        .out_bit(mn_bit), .out_vld(mn_vld), .done(mn_done));

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "max out_vld", mx_vld, e.vld);
            chk(e.tag, "min out_vld", mn_vld, e.vld);
            chk(e.tag, "max done", mx_done, e.dn);
            chk(e.tag, "min done", mn_done, e.dn);
            if (e.vld) begin
                chk(e.tag, "max out_bit", mx_bit, e.mx);
                chk(e.tag, "min out_bit", mn_bit, e.mn);
            end
        end
    end

    // Driver: one cycle of stimulus plus the expected item for it
    task automatic drive(input logic st, input logic bv, input logic a, input logic b,
                         input logic emx, input logic emn, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        start = st; bit_vld = bv; a_bit = a; b_bit = b;
        e.dn  = (bcnt == W);
        e.vld = bv && (st || bcnt != W);
        e.mx  = emx;
        e.mn  = emn;
        e.tag = tag;
        exp_q.push_back(e);
        if (st) bcnt = bv ? 1 : 0;
        else if (e.vld) bcnt++;
    endtask

    // One full word; optional gap after bit 'gap_at' (-1 = none)
    task automatic run_word(input logic [W-1:0] a, input logic [W-1:0] b,
                            input bit joint_start, input int gap_at);
        logic [W-1:0] wmax, wmin;
        bit decided;
        wmax = (a > b) ? a : b;
        wmin = (a > b) ? b : a;
        decided = 1'b0;
        if (!joint_start) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        for (int i = W - 1; i >= 0; i--) begin
            string tag;
            if (joint_start && i == W - 1) tag = "R8";
            else if (!decided && a[i] == b[i]) tag = "R3";
            else if (!decided) tag = "R4";
            else tag = "R5";
            drive(joint_start && i == W - 1, 1'b1, a[i], b[i], wmax[i], wmin[i], tag);
            if (a[i] != b[i]) decided = 1'b1;
            // R9: idle cycle inside the word, flipped inputs must not matter
            if (i == gap_at) drive(1'b0, 1'b0, ~a[i], b[i], 1'b0, 1'b0, "R9");
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        bcnt = 0;
        // R2: reset state, no output while idle
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        // R1/R3: identical words
        run_word(8'h5A, 8'h5A, 1'b0, -1);
        // R6/R7: bits after done ignored
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        // R4: difference at MSB
        run_word(8'h80, 8'h7F, 1'b0, -1);
        // R4: difference only at LSB
        run_word(8'h34, 8'h35, 1'b0, -1);
        // R5/R9: mid difference with a gap after the decision
        run_word(8'hC3, 8'hA5, 1'b0, 5);
        // R5: complementary extremes
        run_word(8'h00, 8'hFF, 1'b0, -1);
        // R8: start together with first bit, previous decision B-larger
        run_word(8'h21, 8'h12, 1'b1, -1);
        run_word(8'h0F, 8'h0F, 1'b1, 6);
        // R6: done seen, then R2 start clears it
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule